// File: doc/BRIEF.md
# Fly-By Block Transfer Engine, Four Channels

This block moves blocks of words between I/O devices and memory for four independently programmed channels. Data never passes through it. For each word it raises a memory strobe and the opposite I/O strobe in the same cycle and drives the memory address, so the device and the memory exchange the word directly on the shared data bus. Transfers always run between one device and memory, never device to device or memory to memory.

Software programs a channel through a small register port while the engine is idle. It writes a start address, a count that holds the number of words minus one, and a mode word that picks the direction and arms the channel. When an armed channel's device raises its request, the engine asks the processor for the bus and waits for the grant. It then strobes the device acknowledge and moves the whole block. After the last word it hands the bus back, disarms the channel, latches a done flag and raises an interrupt. Reading the status register returns the done flags and clears them.

Top module: `fbdma_ctrl`

## Requirements
- R1: After reset, hold_req, irq, every strobe and every dack bit are low, and the status register (select 3) reads 0.
- R2: A device request on an armed channel raises hold_req on the next clock edge while the engine is idle. A request on a channel that is not armed is ignored.
- R3: No dack bit and no strobe is asserted unless both hold_req and hold_ack are high. Once raised, hold_req stays high until the last word of the block has moved.
- R4: When several armed channels request together, the lowest-numbered one is served first and at most one dack bit is high at a time.
- R5: Mode bit 0 = 1 moves memory to device (mem_rd with io_wr). Mode bit 0 = 0 moves device to memory (io_rd with mem_wr). mem_addr carries the channel's current address during each word.
- R6: A count value of N-1 moves exactly N words. The address increments by one and the count decrements by one after each word.
- R7: On the clock edge after the last word, hold_req falls, the channel's mode bit 1 (armed) clears, its done bit at status bit position equal to the channel number sets, and irq goes high.
- R8: Reading select 3 returns the done bits and clears them on that edge. irq falls when no done bit remains.
- R9: Register writes made while hold_req is high are ignored.
- R10: When hold_ack drops during a block, the strobes and dack stop until it returns, and no word is lost or skipped.
- R11: cfg_addr[1:0] selects the register (0 address, 1 count, 2 mode, 3 status). The upper bits select the channel. Selects 0 to 2 read back the programmed or current values, with mode bit 1 = armed and bit 0 = direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (clears status on select 3) |
| cfg_addr | input | CHW+2 | Channel number and register select |
| cfg_wdata | input | DW | Write data |
| cfg_rdata | output | DW | Read data for the selected register |
| dreq | input | NCH | Device requests, one per channel |
| dack | output | NCH | Device acknowledges, one per channel |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address during a word, otherwise 0 |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| irq | output | 1 | Any channel has finished a block |

## Verification
A wrong address or count register appears on mem_addr in the very next word, and a count that is off shows as one word too many or too few with hold_req released at the wrong edge. A sequencer stuck between phases shows within one cycle as a held bus with no strobes, or as strobes without a grant. A lost or stuck done bit appears on irq and in the status read in the cycle after the block ends. The reference model compares every output on every clock, so each of these mismatches is reported in the cycle it first appears.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_MOVE = 2'd2
   } phase_t;

   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_CNT  = 2'd1;
   localparam logic [1:0] SEL_MODE = 2'd2;
   localparam logic [1:0] SEL_STAT = 2'd3;
endpackage

// File: rtl/fbdma_chan.sv
module fbdma_chan #(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_addr,
   input  logic          wr_cnt,
   input  logic          wr_mode,
   input  logic [DW-1:0] wdata,
   input  logic          step,
   output logic [AW-1:0] addr_q,
   output logic [CW-1:0] cnt_q,
   output logic          dir_q,
   output logic          armed_q,
   output logic          last
);
   assign last = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         cnt_q   <= '0;
         dir_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (wr_addr) addr_q <= wdata[AW-1:0];
         if (wr_cnt)  cnt_q  <= wdata[CW-1:0];
         if (wr_mode) begin
            dir_q   <= wdata[0];
            armed_q <= wdata[1];
         end
         if (step) begin
            addr_q <= addr_q + 1'b1;
            cnt_q  <= cnt_q - 1'b1;
            if (last) armed_q <= 1'b0;
         end
      end
   end

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (addr_q == AW'($past(addr_q) + 1'b1)) && (cnt_q == CW'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/fbdma_arb.sv
module fbdma_arb #(
   parameter int NCH = 4,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [NCH-1:0] req,
   output logic           any,
   output logic [CHW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = CHW'(i);
         end
      end
   end
endmodule

// File: rtl/fbdma_seq.sv
module fbdma_seq
   import fbdma_pkg::*;
#(
   parameter int CHW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [CHW-1:0] win_idx,
   input  logic           hold_ack,
   input  logic           act_last,
   output phase_t         phase,
   output logic [CHW-1:0] act_ch,
   output logic           move
);
   assign move = (phase == PH_MOVE) && hold_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         act_ch <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase  <= PH_WAIT;
               act_ch <= win_idx;
            end
            PH_WAIT: if (hold_ack) phase <= PH_MOVE;
            PH_MOVE: if (hold_ack && act_last) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R3
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) && !(move && act_last) |=> (phase != PH_IDLE));
endmodule

// File: rtl/fbdma_ctrl.sv
module fbdma_ctrl
   import fbdma_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 16,
   parameter int CW  = 16,
   parameter int DW  = 16,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic           cfg_re,
   input  logic [CHW+1:0] cfg_addr,
   input  logic [DW-1:0]  cfg_wdata,
   output logic [DW-1:0]  cfg_rdata,
   input  logic [NCH-1:0] dreq,
   output logic [NCH-1:0] dack,
   output logic           hold_req,
   input  logic           hold_ack,
   output logic [AW-1:0]  mem_addr,
   output logic           mem_rd,
   output logic           mem_wr,
   output logic           io_rd,
   output logic           io_wr,
   output logic           irq
);
   generate
      if (NCH < 2)  begin : g_bad_nch  $error("NCH must be at least 2"); end
      if (AW > DW)  begin : g_bad_aw   $error("AW must not exceed DW"); end
      if (CW > DW)  begin : g_bad_cw   $error("CW must not exceed DW"); end
      if (NCH > DW) begin : g_bad_stat $error("status bits must fit in DW"); end
   endgenerate

   logic [1:0]     sel;
   logic [CHW-1:0] csel;
   assign sel  = cfg_addr[1:0];
   assign csel = cfg_addr[CHW+1:2];

   phase_t         phase;
   logic [CHW-1:0] act_ch;
   logic           move;
   logic           idle;
   logic           any_req;
   logic [CHW-1:0] win_idx;

   logic [AW-1:0]  addr_arr [NCH];
   logic [CW-1:0]  cnt_arr  [NCH];
   logic [NCH-1:0] dir_v, arm_v, last_v, step_v, done_set;
   logic [NCH-1:0] done_q;

   assign idle = (phase == PH_IDLE);

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         logic hit;
         assign hit        = cfg_we && idle && (csel == CHW'(gi));
         assign step_v[gi] = move && (act_ch == CHW'(gi));
         assign done_set[gi] = step_v[gi] && last_v[gi];

         fbdma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_addr (hit && (sel == SEL_ADDR)),
            .wr_cnt  (hit && (sel == SEL_CNT)),
            .wr_mode (hit && (sel == SEL_MODE)),
            .wdata   (cfg_wdata),
            .step    (step_v[gi]),
            .addr_q  (addr_arr[gi]),
            .cnt_q   (cnt_arr[gi]),
            .dir_q   (dir_v[gi]),
            .armed_q (arm_v[gi]),
            .last    (last_v[gi])
         );
      end
   endgenerate

   fbdma_arb #(.NCH(NCH)) u_arb (
      .req (dreq & arm_v),
      .any (any_req),
      .idx (win_idx)
   );

   fbdma_seq #(.CHW(CHW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (any_req),
      .win_idx  (win_idx),
      .hold_ack (hold_ack),
      .act_last (last_v[act_ch]),
      .phase    (phase),
      .act_ch   (act_ch),
      .move     (move)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= '0;
      else if (cfg_re && (sel == SEL_STAT)) done_q <= done_set;
      else done_q <= done_q | done_set;
   end

   assign hold_req = !idle;
   assign dack     = step_v;
   assign mem_addr = move ? addr_arr[act_ch] : '0;
   assign mem_rd   = move &&  dir_v[act_ch];
   assign io_wr    = move &&  dir_v[act_ch];
   assign io_rd    = move && !dir_v[act_ch];
   assign mem_wr   = move && !dir_v[act_ch];
   assign irq      = |done_q;

   always_comb begin
      case (sel)
         SEL_ADDR: cfg_rdata = DW'(addr_arr[csel]);
         SEL_CNT:  cfg_rdata = DW'(cnt_arr[csel]);
         SEL_MODE: cfg_rdata = DW'({arm_v[csel], dir_v[csel]});
         default:  cfg_rdata = DW'(done_q);
      endcase
   end

   // R3
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || io_rd || io_wr || (|dack)) |-> (hold_req && hold_ack));
   // R4
   dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));
   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_req) |-> irq);
   // R5
   strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> ((io_wr != io_rd) && (io_wr == mem_rd)));
endmodule

// File: tb/fbdma_ctrl_bench.sv
`timescale 1ns/100ps
module fbdma_ctrl_bench;
   localparam int NCH = 4;
   localparam int AW  = 16;
   localparam int DW  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0, cfg_re = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic [DW-1:0] cfg_rdata;
   logic [NCH-1:0] dreq = '0, dack;
   logic          hold_req, hold_ack = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr, io_rd, io_wr, irq;
   logic          ack_en = 1'b1;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   fbdma_ctrl u_fbdma_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .dreq(dreq), .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
   );

   // processor side: grant follows the request one cycle later
   always @(posedge clk) begin
      #1 hold_ack = hold_req && ack_en;
   end

   // behavioural reference model
   int m_phase, m_ch, m_done;
   int m_addr [NCH], m_cnt [NCH], m_dir [NCH], m_en [NCH];

   always @(posedge clk) begin
      int win, setm, c, s;
      if (!rst_n) begin
         m_phase = 0; m_ch = 0; m_done = 0;
         for (int i = 0; i < NCH; i++) begin
            m_addr[i] = 0; m_cnt[i] = 0; m_dir[i] = 0; m_en[i] = 0;
         end
      end else begin
         win = -1; setm = 0;
         c = int'(cfg_addr[3:2]); s = int'(cfg_addr[1:0]);
         if (m_phase == 0)
            for (int i = 0; i < NCH; i++)
               if (win < 0 && dreq[i] && m_en[i] != 0) win = i;
         if (m_phase == 0 && cfg_we) begin
            if (s == 0) m_addr[c] = int'(cfg_wdata);
            if (s == 1) m_cnt[c]  = int'(cfg_wdata);
            if (s == 2) begin m_dir[c] = int'(cfg_wdata[0]); m_en[c] = int'(cfg_wdata[1]); end
         end
         case (m_phase)
            0: if (win >= 0) begin m_phase = 1; m_ch = win; end
            1: if (hold_ack) m_phase = 2;
            default: if (hold_ack) begin
               if (m_cnt[m_ch] == 0) begin
                  m_en[m_ch] = 0; setm = 1 << m_ch; m_phase = 0;
               end
               m_addr[m_ch] = (m_addr[m_ch] + 1) & 16'hFFFF;
               m_cnt[m_ch]  = (m_cnt[m_ch] - 1) & 16'hFFFF;
            end
         endcase
         if (cfg_re && s == 3) m_done = 0;
         m_done = m_done | setm;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      int mv, ex;
      if (rst_n && !finished) begin
         mv = (m_phase == 2 && hold_ack) ? 1 : 0;
         chk(int'(hold_req) == (m_phase != 0 ? 1 : 0), "R3 hold_req", int'(hold_req), int'(m_phase != 0));
         ex = mv ? (1 << m_ch) : 0;
         chk(int'(dack) == ex, "R4 dack", int'(dack), ex);
         ex = mv && m_dir[m_ch] != 0;
         chk(int'(mem_rd) == ex && int'(io_wr) == ex, "R5 mem_rd/io_wr", int'({mem_rd, io_wr}), ex * 3);
         ex = mv && m_dir[m_ch] == 0;
         chk(int'(io_rd) == ex && int'(mem_wr) == ex, "R5 io_rd/mem_wr", int'({io_rd, mem_wr}), ex * 3);
         ex = mv ? m_addr[m_ch] : 0;
         chk(int'(mem_addr) == ex, "R6 mem_addr", int'(mem_addr), ex);
         chk(int'(irq) == (m_done != 0 ? 1 : 0), "R7 irq", int'(irq), int'(m_done != 0));
         case (int'(cfg_addr[1:0]))
            0: ex = m_addr[cfg_addr[3:2]];
            1: ex = m_cnt[cfg_addr[3:2]];
            2: ex = m_en[cfg_addr[3:2]] * 2 + m_dir[cfg_addr[3:2]];
            default: ex = m_done;
         endcase
         chk(int'(cfg_rdata) == ex, "R11 cfg_rdata", int'(cfg_rdata), ex);
      end
   end

   int words [NCH];
   int first_dack;
   int paused_strobes;
   always @(negedge clk) begin
      for (int i = 0; i < NCH; i++) if (dack[i]) words[i]++;
      if (first_dack < 0 && dack != 0)
         for (int i = 0; i < NCH; i++) if (dack[i]) first_dack = i;
      if (hold_req && !hold_ack && (mem_rd || mem_wr || io_rd || io_wr)) paused_strobes++;
   end

   task automatic step_in();
      @(posedge clk); #1;
   endtask

   task automatic wr(input int ch, input int s, input int d);
      step_in();
      cfg_addr = 4'((ch << 2) | s); cfg_wdata = 16'(d); cfg_we = 1'b1;
      step_in();
      cfg_we = 1'b0;
   endtask

   task automatic rd(input int ch, input int s, input int exp, input string tag);
      step_in();
      cfg_addr = 4'((ch << 2) | s);
      @(negedge clk);
      chk(int'(cfg_rdata) == exp, tag, int'(cfg_rdata), exp);
   endtask

   task automatic rd_clear();
      step_in();
      cfg_addr = 4'd3; cfg_re = 1'b1;
      step_in();
      cfg_re = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (hold_req && n < 1000) begin @(negedge clk); n++; end
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         finished = 1;
         bad++; total++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      first_dack = -1;
      for (int i = 0; i < NCH; i++) words[i] = 0;
      paused_strobes = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!hold_req && !irq && dack == 0 && !mem_rd && !mem_wr && !io_rd && !io_wr,
          "R1 outputs after reset", int'({hold_req, irq, dack}), 0);
      rd(0, 3, 0, "R1 status after reset");

      // R2 unarmed request ignored
      step_in(); dreq = 4'b0100;
      repeat (3) @(negedge clk);
      chk(!hold_req, "R2 unarmed request ignored", int'(hold_req), 0);
      dreq = '0;

      // channel 2: memory to device, 3 words from 0x100
      wr(2, 0, 16'h0100);
      wr(2, 1, 2);
      wr(2, 2, 3);
      rd(2, 2, 3, "R11 mode readback");
      step_in(); dreq = 4'b0100;
      @(negedge clk); @(negedge clk);
      chk(hold_req, "R2 hold_req raised", int'(hold_req), 1);
      wait_idle();
      dreq = '0;
      chk(words[2] == 3, "R6 word count ch2", words[2], 3);
      chk(irq, "R7 irq after block", int'(irq), 1);
      rd(2, 2, 1, "R7 channel disarmed");
      rd(2, 0, 16'h0103, "R6 final address");
      rd(0, 3, 4, "R7 done bit 2");
      rd_clear();
      @(negedge clk);
      chk(!irq, "R8 irq cleared by status read", int'(irq), 0);
      rd(0, 3, 0, "R8 status cleared");

      // R4 arbitration, R9 ignored writes, R5 device to memory
      wr(1, 0, 16'h0200); wr(1, 1, 3); wr(1, 2, 2);
      wr(3, 0, 16'h0300); wr(3, 1, 1); wr(3, 2, 2);
      first_dack = -1;
      step_in(); dreq = 4'b1010;
      @(negedge clk); @(negedge clk);
      wr(3, 0, 16'h0777);
      wait_idle();
      chk(first_dack == 1, "R4 lowest channel first", first_dack, 1);
      step_in();
      wait_idle();
      dreq = '0;
      chk(words[1] == 4 && words[3] == 2, "R6 word counts ch1/ch3", words[1] * 16 + words[3], 16'h42);
      rd(3, 0, 16'h0302, "R9 write during transfer ignored");
      rd(0, 3, 10, "R8 status shows ch1 and ch3");
      rd_clear();

      // R10 grant withdrawn mid-block
      wr(0, 0, 16'h0400); wr(0, 1, 5); wr(0, 2, 3);
      step_in(); dreq = 4'b0001;
      repeat (5) @(negedge clk);
      step_in(); ack_en = 1'b0;
      repeat (4) @(negedge clk);
      chk(hold_req && dack == 0, "R10 paused while grant low", int'({hold_req, dack}), 16);
      step_in(); ack_en = 1'b1;
      wait_idle();
      dreq = '0;
      chk(words[0] == 6, "R10 no word lost", words[0], 6);
      chk(paused_strobes == 0, "R3 no strobe without grant", paused_strobes, 0);
      rd(0, 0, 16'h0406, "R10 final address ch0");
      rd_clear();
      repeat (3) @(negedge clk);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule